// File: doc/BRIEF.md
# Field-Synchronous Page Flip And Blank Controller

This block sits between a processor's register bus and the video path. Software chooses which display page the video fetch logic reads, and whether the visible picture is suppressed. Both choices are written into pending registers at any time. They reach the active registers only on the start-of-field strobe from the timing generator. Page changes and blanking changes therefore take effect exactly on a field boundary, and every displayed interval is a whole number of field periods.

The active page index is turned into a memory origin for the fetch logic, at index times a fixed page span. While blanking is active the registered pixel output is held at zero. The contents of display memory are never touched. Software can learn where the beam is in three ways. It can read the live vertical sync level, which has an address of its own and shares it with no other input. It can read a sticky field-seen flag, which is cleared by reading it. It can read a free-running field counter to measure durations in fields.

Top module: `pfb_ctrl`

## Requirements
- R1: After reset the active and pending page are 0, so `page_origin` is 0. The display is visible: the show bit is 1 in both the active and pending registers. The field counter is 0 and the field-seen flag is 0.
- R2: On a cycle with `field_start` high, the pending page and pending show bit are copied into the active registers. From the next cycle on, `page_origin` equals active page × PAGE_SPAN.
- R3: When `field_start` is low, the active page and active show bit keep their values. A bus write changes only the pending registers, and these read back at address 0 (page, bits [PAGE_W-1:0]) and address 1 (show, bit 0).
- R4: A write to address 0 whose data is NUM_PAGES or larger is ignored, and the pending page keeps its value.
- R5: `pix_out` is registered one cycle after `pix_in`. It equals `pix_in` when the active show bit is 1 and is all zeros when the show bit is 0.
- R6: A read of address 2 returns the live `vsync_level` in bit 0 and zeros in every other bit.
- R7: Address 3 bit 0 is a field-seen flag. It is set by `field_start` and cleared by a read of address 3. When the two happen in the same cycle the set wins, and the read returns the old value.
- R8: Address 4 returns a field counter of FIELD_CNT_W bits. It adds one on each `field_start` and wraps to 0 after its largest value.
- R9: `bus_rdata` carries the value read in the cycle after `bus_rd`. Address 5 returns the active show bit in bit 0 and the active page in bits [PAGE_W:1]. Addresses 6 and 7 read as zero.
- R10: A page or show write in the same cycle as `field_start` updates the pending register. The active register takes the pending value from before that write, and the new value reaches the active register on the following field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| field_start | input | 1 | One-cycle start-of-field strobe from the timing generator |
| vsync_level | input | 1 | Live vertical sync level |
| pix_in | input | PIX_W | Dots from the display shifter |
| pix_out | output | PIX_W | Gated dots |
| page_origin | output | ORIGIN_W | Memory origin of the active page |

## Verification
The hardest case to reach is a bus access that falls in the same clock as the field strobe. This covers both a page write that must miss the current transfer and a flag read that must not swallow a new field. The bench drives the write or read strobe and `field_start` on the same falling edge, so both are sampled by one rising edge. It then reads the pending, active and flag registers back to show which value landed where. Counter wrap is reached by building the bench with a narrow counter and stepping it past its top value.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int BUS_AW = 3;

    typedef enum logic [BUS_AW-1:0] {
        REG_PAGE   = 3'd0,
        REG_SHOW   = 3'd1,
        REG_VSYNC  = 3'd2,
        REG_SEEN   = 3'd3,
        REG_FIELDS = 3'd4,
        REG_ACTIVE = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        reg_addr_e addr;
    } bus_req_t;

    function automatic bus_req_t make_req(input logic wr, input logic rd,
                                          input logic [BUS_AW-1:0] a);
        bus_req_t r;
        r.wr   = wr;
        r.rd   = rd;
        r.addr = reg_addr_e'(a);
        return r;
    endfunction

    function automatic logic is_access(input bus_req_t r, input reg_addr_e a);
        return r.addr == a;
    endfunction

endpackage

// File: rtl/pfb_pending_regs.sv
module pfb_pending_regs
    import pfb_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int DATA_W    = 16,
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] pend_page,
    output logic              pend_show
);

    logic page_legal;
    logic page_wr;
    logic show_wr;

    always_comb begin
        page_legal = wdata < DATA_W'(NUM_PAGES);
        page_wr    = req.wr && is_access(req, REG_PAGE) && page_legal;
        show_wr    = req.wr && is_access(req, REG_SHOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_page <= '0;
            pend_show <= 1'b1;
        end else begin
            if (page_wr) pend_page <= wdata[PAGE_W-1:0];
            if (show_wr) pend_show <= wdata[0];
        end
    end

    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (req.wr && is_access(req, REG_PAGE) && !page_legal) |=> $stable(pend_page)) // R4
        else $error("illegal page write changed pending page");

    AST_PEND_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(pend_page) < NUM_PAGES)) // R4
        else $error("pending page out of range");

endmodule

// File: rtl/pfb_field_sync.sv
module pfb_field_sync #(
    parameter int PAGE_W      = 2,
    parameter int FIELD_CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   field_start,
    input  logic [PAGE_W-1:0]      pend_page,
    input  logic                   pend_show,
    input  logic                   seen_clr,
    output logic [PAGE_W-1:0]      act_page,
    output logic                   act_show,
    output logic [FIELD_CNT_W-1:0] field_cnt,
    output logic                   seen
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_page <= '0;
            act_show <= 1'b1;
        end else if (field_start) begin
            act_page <= pend_page;
            act_show <= pend_show;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) field_cnt <= '0;
        else if (field_start) field_cnt <= field_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else if (field_start) seen <= 1'b1;
        else if (seen_clr) seen <= 1'b0;
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> ($stable(act_page) && $stable(act_show))) // R3
        else $error("active state moved without field start");

    AST_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        field_start |=> (act_page == $past(pend_page) && act_show == $past(pend_show))) // R2
        else $error("pending state not transferred");

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        field_start |=> field_cnt == $past(field_cnt) + 1'b1) // R8
        else $error("field counter step wrong");

    AST_SEEN_SET: assert property (@(posedge clk) disable iff (rst)
        field_start |=> seen) // R7
        else $error("field-seen flag not set");

    AST_SEEN_CLR: assert property (@(posedge clk) disable iff (rst)
        (seen_clr && !field_start) |=> !seen) // R7
        else $error("field-seen flag not cleared");

endmodule

// File: rtl/pfb_pixel_gate.sv
module pfb_pixel_gate #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             show,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out
);

    for (genvar b = 0; b < PIX_W; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) pix_out[b] <= 1'b0;
            else     pix_out[b] <= pix_in[b] & show;
        end
    end

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        !show |=> pix_out == '0) // R5
        else $error("blanked output not zero");

    AST_PASS_DOTS: assert property (@(posedge clk) disable iff (rst)
        show |=> pix_out == $past(pix_in)) // R5
        else $error("visible output not passing dots");

endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
    import pfb_pkg::*;
#(
    parameter int NUM_PAGES   = 4,
    parameter int DATA_W      = 16,
    parameter int PIX_W       = 8,
    parameter int ORIGIN_W    = 16,
    parameter int PAGE_SPAN   = 'h400,
    parameter int FIELD_CNT_W = 16,
    localparam int PAGE_W     = $clog2(NUM_PAGES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                field_start,
    input  logic                vsync_level,
    input  logic [PIX_W-1:0]    pix_in,
    output logic [PIX_W-1:0]    pix_out,
    output logic [ORIGIN_W-1:0] page_origin
);

    bus_req_t               req;
    logic [PAGE_W-1:0]      pend_page;
    logic                   pend_show;
    logic [PAGE_W-1:0]      act_page;
    logic                   act_show;
    logic [FIELD_CNT_W-1:0] field_cnt;
    logic                   seen;
    logic                   seen_clr;
    logic [DATA_W-1:0]      rd_mux;

    assign req      = make_req(bus_wr, bus_rd, bus_addr);
    assign seen_clr = req.rd && is_access(req, REG_SEEN);

    pfb_pending_regs #(
        .NUM_PAGES (NUM_PAGES),
        .DATA_W    (DATA_W)
    ) i_pend (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wdata     (bus_wdata),
        .pend_page (pend_page),
        .pend_show (pend_show)
    );

    pfb_field_sync #(
        .PAGE_W      (PAGE_W),
        .FIELD_CNT_W (FIELD_CNT_W)
    ) i_sync (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .pend_page   (pend_page),
        .pend_show   (pend_show),
        .seen_clr    (seen_clr),
        .act_page    (act_page),
        .act_show    (act_show),
        .field_cnt   (field_cnt),
        .seen        (seen)
    );

    pfb_pixel_gate #(
        .PIX_W (PIX_W)
    ) i_gate (
        .clk     (clk),
        .rst     (rst),
        .show    (act_show),
        .pix_in  (pix_in),
        .pix_out (pix_out)
    );

    assign page_origin = ORIGIN_W'(act_page) * ORIGIN_W'(PAGE_SPAN);

    always_comb begin
        rd_mux = '0;
        case (req.addr)
            REG_PAGE:   rd_mux[PAGE_W-1:0]      = pend_page;
            REG_SHOW:   rd_mux[0]               = pend_show;
            REG_VSYNC:  rd_mux[0]               = vsync_level;
            REG_SEEN:   rd_mux[0]               = seen;
            REG_FIELDS: rd_mux[FIELD_CNT_W-1:0] = field_cnt;
            REG_ACTIVE: rd_mux[PAGE_W:0]        = {act_page, act_show};
            default:    rd_mux                  = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_ORIGIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(page_origin)) // R3
        else $error("origin moved between fields");

    AST_VSYNC_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd2) |=> bus_rdata == DATA_W'($past(vsync_level))) // R6
        else $error("vsync read wrong");

endmodule

// File: tb/test_pfb_ctrl.sv
module test_pfb_ctrl;

    localparam int NUM_PAGES = 4;
    localparam int DATA_W    = 16;
    localparam int PIX_W     = 8;
    localparam int ORIGIN_W  = 16;
    localparam int SPAN      = 'h400;
    localparam int CNT_W     = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bus_wr = 1'b0;
    logic                bus_rd = 1'b0;
    logic [2:0]          bus_addr = '0;
    logic [DATA_W-1:0]   bus_wdata = '0;
    logic [DATA_W-1:0]   bus_rdata;
    logic                field_start = 1'b0;
    logic                vsync_level = 1'b0;
    logic [PIX_W-1:0]    pix_in = '0;
    logic [PIX_W-1:0]    pix_out;
    logic [ORIGIN_W-1:0] page_origin;

    int checks = 0;
    int fails  = 0;
    int nfields = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfb_ctrl #(
        .NUM_PAGES   (NUM_PAGES),
        .DATA_W      (DATA_W),
        .PIX_W       (PIX_W),
        .ORIGIN_W    (ORIGIN_W),
        .PAGE_SPAN   (SPAN),
        .FIELD_CNT_W (CNT_W)
    ) i_pfb_ctrl (
        .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .field_start (field_start), .vsync_level (vsync_level),
        .pix_in (pix_in), .pix_out (pix_out), .page_origin (page_origin)
    );

    // {page, show, pix_in, expected pix_out}
    localparam logic [31:0] VEC [8] = '{
        {8'd0, 8'd1, 8'hA5, 8'hA5},
        {8'd1, 8'd1, 8'h3C, 8'h3C},
        {8'd2, 8'd0, 8'hFF, 8'h00},
        {8'd3, 8'd0, 8'h81, 8'h00},
        {8'd3, 8'd1, 8'h81, 8'h81},
        {8'd1, 8'd0, 8'h7E, 8'h00},
        {8'd2, 8'd1, 8'h01, 8'h01},
        {8'd0, 8'd1, 8'hFF, 8'hFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic field();
        @(negedge clk);
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        nfields++;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [DATA_W-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 origin", 32'(page_origin), 0);
        rd(3'd0, d); chk("R1 pend page", 32'(d), 0);
        rd(3'd1, d); chk("R1 pend show", 32'(d), 1);
        rd(3'd5, d); chk("R1 active", 32'(d), 1);
        rd(3'd4, d); chk("R1 fields", 32'(d), 0);
        rd(3'd3, d); chk("R1 seen", 32'(d), 0);

        // R2 R5 table
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, DATA_W'(VEC[i][31:24]));
            wr(3'd1, DATA_W'(VEC[i][23:16]));
            field();
            pix_in = VEC[i][15:8];
            @(negedge clk);
            chk("R2 origin", 32'(page_origin), 32'(VEC[i][31:24]) * SPAN);
            chk("R5 pix_out", 32'(pix_out), 32'(VEC[i][7:0]));
        end

        // R3 writes touch pending only
        wr(3'd0, 16'd3);
        wr(3'd1, 16'd0);
        repeat (3) @(negedge clk);
        chk("R3 origin held", 32'(page_origin), 0);
        pix_in = 8'h5A;
        @(negedge clk);
        chk("R3 pix still visible", 32'(pix_out), 32'h5A);
        rd(3'd0, d); chk("R3 pend page", 32'(d), 3);
        rd(3'd1, d); chk("R3 pend show", 32'(d), 0);
        rd(3'd5, d); chk("R9 R3 active", 32'(d), 1);

        // R4 illegal page ignored
        wr(3'd0, 16'd4);
        rd(3'd0, d); chk("R4 pend page kept", 32'(d), 3);
        wr(3'd0, 16'h8001);
        rd(3'd0, d); chk("R4 wide data ignored", 32'(d), 3);
        field();
        @(negedge clk);
        chk("R4 R2 origin", 32'(page_origin), 3 * SPAN);
        rd(3'd5, d); chk("R9 active page3 blanked", 32'(d), 32'h6);

        // R10 write coincident with field strobe
        wr(3'd0, 16'd1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'd2; field_start = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; field_start = 1'b0; nfields++;
        chk("R10 active took old pending", 32'(page_origin), 1 * SPAN);
        rd(3'd0, d); chk("R10 pending new", 32'(d), 2);
        field();
        @(negedge clk);
        chk("R10 next field", 32'(page_origin), 2 * SPAN);

        // R6 live vsync
        vsync_level = 1'b1;
        rd(3'd2, d); chk("R6 vsync high", 32'(d), 1);
        vsync_level = 1'b0;
        rd(3'd2, d); chk("R6 vsync low", 32'(d), 0);

        // R7 sticky flag
        rd(3'd3, d); chk("R7 seen after fields", 32'(d), 1);
        rd(3'd3, d); chk("R7 cleared by read", 32'(d), 0);
        field();
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'd3; field_start = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; field_start = 1'b0; nfields++;
        chk("R7 coincident read old", 32'(bus_rdata), 1);
        rd(3'd3, d); chk("R7 set wins", 32'(d), 1);
        rd(3'd3, d); chk("R7 clear", 32'(d), 0);

        // R8 counter and wrap
        rd(3'd4, d); chk("R8 count", 32'(d), 32'(nfields % 16));
        for (int k = 0; k < 20; k++) field();
        rd(3'd4, d); chk("R8 wrap", 32'(d), 32'(nfields % 16));

        // R9 unmapped
        rd(3'd7, d); chk("R9 unmapped 7", 32'(d), 0);
        rd(3'd6, d); chk("R9 unmapped 6", 32'(d), 0);

        // R1 reset again after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 origin after reset", 32'(page_origin), 0);
        rd(3'd4, d); chk("R1 fields after reset", 32'(d), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule